// File: doc/BRIEF.md
# Guarded HDR Transition Controller

This block decides, for one bus segment, when the controller may leave the slow open-drain compatibility mode for HDR signalling and when it must come back. It never treats HDR as a plain switch. An entry attempt starts only on a fresh permission pulse from the capability gate. It then runs a precheck. The segment must be proven to carry only HDR-capable targets, the bus must have been idle for a guard time, no in-band interrupt storm may be flagged, and every critical target must report ready. Only when all of these hold does the HDR enable rise.

The precheck has a cycle budget and a bounded number of extra windows. When these are used up, the controller falls back with a reason code, and it makes no silent further attempts. While in HDR it counts link errors and short timeouts against limits. A long timeout, or a host exit request, ends HDR at once. Every exit goes through a verify phase, and HDR is not considered closed until the bus is idle and the critical targets have answered. A failed or late verify forces fallback and pulses a request to re-run discovery.

Each failure records a 4-bit reason code whose upper two bits give its class, together with the segment id and the retry count at the moment of failure. The controller also measures the time from exit until verify passes.

Top module: `hdr_guard_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (Normal), hdr_en_o is 0, and reason_o, reason_cnt_o, missing_o, rediscover_o and time_to_stable_o are all 0.
- R2: An attempt starts only on a 0-to-1 change of gate_allow_i sampled while in Normal, and mode_o reads 1 (Precheck) one cycle later. A gate level held high across a return to Normal starts nothing.
- R3: The precheck counts bus idle as proven only after bus_idle_i has been sampled high on GUARD_CYC consecutive clock edges. A low sample restarts that count.
- R4: The edge after all precheck conditions hold (purity_i equal to 2, guard met, ibi_storm_i low, every bit of crit_mask_i also set in ready_mask_i), mode_o becomes 2 (HDR) and hdr_en_o is 1. hdr_en_o is 1 only while mode_o is 2.
- R5: If purity_i is any value other than 2 (0 unknown, 1 mixed, 3 reserved) on a precheck edge, mode_o becomes 4 (Fallback) at that edge, with reason 0x4 and reason_cnt_o 0.
- R6: On each precheck edge, missing_o is loaded with crit_mask_i AND NOT ready_mask_i. It holds that value outside Precheck, and while it is non-zero entry is denied.
- R7: A precheck window lasts ENTRY_BUDGET cycles and is repeated at most ENTRY_RETRIES more times. When the last window expires, mode_o becomes 4. The reason is 0x8 if a critical target is missing, otherwise 0x6 if the storm flag is set, otherwise 0x5 (bus not idle). reason_cnt_o then equals ENTRY_RETRIES and reason_seg_o equals seg_id_i. If the conditions become true in a later window, HDR is entered and reason_o stays 0.
- R8: In HDR, each cycle with err_crc_i or err_retry_i high counts as one link error. The event that takes the count past LINK_RETRY_LIM moves mode_o to 3 (Exit Verify) with reason 0xC and reason_cnt_o equal to LINK_RETRY_LIM.
- R9: In HDR, the short timeout that takes its count past SHORT_RETRY_LIM moves to Exit Verify with reason 0xD. A single long timeout moves there at once with reason 0xE. Precedence is long timeout, then link errors, then short timeouts, then exit_req_i.
- R10: Exit Verify returns to Normal only on an edge with verify_done_i, verify_pass_i and bus_idle_i all high. time_to_stable_o is then set to the number of edges from the exit edge to that edge.
- R11: In Exit Verify, a done with a failed result gives reason 0x9. A done with a pass but the bus not idle gives 0x5. No done within VERIFY_BUDGET edges gives 0xA. Each case moves to Fallback, and rediscover_o is high for exactly the first Fallback cycle.
- R12: Fallback ignores gate_allow_i and returns to Normal on the first edge with bus_idle_i high. A new attempt then needs a new rising edge of the gate.
- R13: Bits [3:2] of reason_o give the class: 1 for bus, 2 for target, 3 for link, 0 for no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_id_i | input | SEG_W | Segment identifier recorded with failures |
| gate_allow_i | input | 1 | Capability gate permission; its rising edge starts an attempt |
| purity_i | input | 2 | Segment purity: 0 unknown, 1 mixed, 2 HDR-capable only |
| bus_idle_i | input | 1 | Bus idle status |
| ibi_storm_i | input | 1 | In-band interrupt storm flag |
| ready_mask_i | input | N_TGT | Targets reporting ready |
| crit_mask_i | input | N_TGT | Targets that must be ready |
| err_crc_i | input | 1 | HDR CRC error event |
| err_retry_i | input | 1 | HDR retry event |
| to_short_i | input | 1 | HDR short timeout event |
| to_long_i | input | 1 | HDR long timeout event |
| exit_req_i | input | 1 | Host request to leave HDR |
| verify_done_i | input | 1 | Post-exit verify finished |
| verify_pass_i | input | 1 | Post-exit verify result |
| mode_o | output | 3 | 0 Normal, 1 Precheck, 2 HDR, 3 Exit Verify, 4 Fallback |
| hdr_en_o | output | 1 | HDR signalling enable |
| reason_o | output | 4 | Last failure reason code |
| reason_seg_o | output | SEG_W | Segment id captured with the reason |
| reason_cnt_o | output | REC_W | Retry count captured with the reason |
| missing_o | output | N_TGT | Critical targets not ready at the last precheck edge |
| rediscover_o | output | 1 | One-cycle request to re-run discovery |
| time_to_stable_o | output | TTS_W | Edges from exit to a passing verify |

## Verification
Every output comes from a register, so each result appears one clock edge after the inputs that cause it. A gate rise shows as Precheck after one edge. A clean precheck shows as HDR after the second edge. A budget failure with one retry shows as Fallback on the eighth edge after Precheck starts. An in-HDR error shows as Exit Verify on the same edge that counts it. The bench drives inputs two nanoseconds after a rising edge and reads the outputs at that same point after the next edge. It counts edges explicitly for every expected transition, and it checks both the last cycle before each budget or limit runs out and the cycle in which it does.

// File: rtl/hdr_guard_pkg.sv
package hdr_guard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_PRECHECK = 3'd1,
        ST_HDR      = 3'd2,
        ST_VERIFY   = 3'd3,
        ST_FALLBACK = 3'd4
    } hg_state_e;

    localparam logic [1:0] PUR_NATIVE_ONLY = 2'd2;

    // reason code: [3:2] class (1 bus, 2 target, 3 link), [1:0] subtype
    localparam logic [3:0] RSN_NONE           = 4'h0;
    localparam logic [3:0] RSN_BUS_PURITY     = 4'h4;
    localparam logic [3:0] RSN_BUS_NOT_IDLE   = 4'h5;
    localparam logic [3:0] RSN_BUS_IBI_STORM  = 4'h6;
    localparam logic [3:0] RSN_TGT_NOT_READY  = 4'h8;
    localparam logic [3:0] RSN_TGT_VERIFY     = 4'h9;
    localparam logic [3:0] RSN_TGT_VERIFY_TO  = 4'hA;
    localparam logic [3:0] RSN_LNK_ERRORS     = 4'hC;
    localparam logic [3:0] RSN_LNK_SHORT_TO   = 4'hD;
    localparam logic [3:0] RSN_LNK_LONG_TO    = 4'hE;

endpackage

// File: rtl/hdr_guard_idle_timer.sv
module hdr_guard_idle_timer #(
    parameter int GUARD_CYC = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_idle_i,
    output logic idle_ok_o
);
    localparam int CW = $clog2(GUARD_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(GUARD_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!bus_idle_i) begin
            cnt_d = '0;
        end else if (cnt_q != CMAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idle_ok_o = (cnt_q == CMAX);

    // R3: proven idle implies the bus was idle on the previous edge
    a_r3_guard_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_ok_o |-> $past(bus_idle_i));

endmodule

// File: rtl/hdr_guard_ready_cmp.sv
module hdr_guard_ready_cmp #(
    parameter int N_TGT = 4
) (
    input  logic [N_TGT-1:0] ready_i,
    input  logic [N_TGT-1:0] crit_i,
    output logic [N_TGT-1:0] missing_o,
    output logic             covered_o
);
    genvar g;
    generate
        for (g = 0; g < N_TGT; g++) begin : g_bit
            assign missing_o[g] = crit_i[g] & ~ready_i[g];
        end
    endgenerate

    assign covered_o = (missing_o == '0);

    // R6: covered means no critical target lacks ready
    always_comb begin
        a_r6_cover_consistent: assert (!covered_o || ((crit_i & ~ready_i) == '0));
    end

endmodule

// File: rtl/hdr_guard_evt_cnt.sv
module hdr_guard_evt_cnt #(
    parameter int LIM = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_lim_o
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIM);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != CMAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_lim_o = (cnt_q == CMAX);

    // R8/R9: the limit is reached only through a counted event
    a_r8_lim_by_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(at_lim_o) |-> $past(inc_i));

endmodule

// File: rtl/hdr_guard_ctrl.sv
module hdr_guard_ctrl
    import hdr_guard_pkg::*;
#(
    parameter int N_TGT           = 4,
    parameter int SEG_W           = 3,
    parameter int GUARD_CYC       = 3,
    parameter int ENTRY_BUDGET    = 4,
    parameter int ENTRY_RETRIES   = 1,
    parameter int LINK_RETRY_LIM  = 2,
    parameter int SHORT_RETRY_LIM = 1,
    parameter int VERIFY_BUDGET   = 8,
    parameter int TTS_W           = 16,
    parameter int REC_W           = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEG_W-1:0] seg_id_i,
    input  logic             gate_allow_i,
    input  logic [1:0]       purity_i,
    input  logic             bus_idle_i,
    input  logic             ibi_storm_i,
    input  logic [N_TGT-1:0] ready_mask_i,
    input  logic [N_TGT-1:0] crit_mask_i,
    input  logic             err_crc_i,
    input  logic             err_retry_i,
    input  logic             to_short_i,
    input  logic             to_long_i,
    input  logic             exit_req_i,
    input  logic             verify_done_i,
    input  logic             verify_pass_i,
    output logic [2:0]       mode_o,
    output logic             hdr_en_o,
    output logic [3:0]       reason_o,
    output logic [SEG_W-1:0] reason_seg_o,
    output logic [REC_W-1:0] reason_cnt_o,
    output logic [N_TGT-1:0] missing_o,
    output logic             rediscover_o,
    output logic [TTS_W-1:0] time_to_stable_o
);
    localparam int TW = $clog2(ENTRY_BUDGET);
    localparam int RW = $clog2(ENTRY_RETRIES + 1);
    localparam logic [TW-1:0]    TMR_LAST = TW'(ENTRY_BUDGET - 1);
    localparam logic [RW-1:0]    RTRY_MAX = RW'(ENTRY_RETRIES);
    localparam logic [TTS_W-1:0] VFY_LAST = TTS_W'(VERIFY_BUDGET - 1);

    typedef struct packed {
        hg_state_e         st;
        logic [TW-1:0]     tmr;
        logic [RW-1:0]     rtry;
        logic [TTS_W-1:0]  tts;
        logic [TTS_W-1:0]  tts_out;
        logic [3:0]        rsn;
        logic [SEG_W-1:0]  rsn_seg;
        logic [REC_W-1:0]  rsn_cnt;
        logic [N_TGT-1:0]  miss;
        logic              redisc;
        logic              gate;
    } ctrl_t;

    ctrl_t q, n;

    logic             idle_ok;
    logic [N_TGT-1:0] missing;
    logic             covered;
    logic             in_hdr;
    logic             link_inc, short_inc;
    logic             link_at_lim, short_at_lim;
    logic             pre_pass;

    hdr_guard_idle_timer #(.GUARD_CYC(GUARD_CYC)) i_idle (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bus_idle_i (bus_idle_i),
        .idle_ok_o  (idle_ok)
    );

    hdr_guard_ready_cmp #(.N_TGT(N_TGT)) i_ready (
        .ready_i   (ready_mask_i),
        .crit_i    (crit_mask_i),
        .missing_o (missing),
        .covered_o (covered)
    );

    assign in_hdr    = (q.st == ST_HDR);
    assign link_inc  = in_hdr & (err_crc_i | err_retry_i);
    assign short_inc = in_hdr & to_short_i;

    hdr_guard_evt_cnt #(.LIM(LINK_RETRY_LIM)) i_link_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (~in_hdr),
        .inc_i    (link_inc),
        .at_lim_o (link_at_lim)
    );

    hdr_guard_evt_cnt #(.LIM(SHORT_RETRY_LIM)) i_short_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (~in_hdr),
        .inc_i    (short_inc),
        .at_lim_o (short_at_lim)
    );

    assign pre_pass = idle_ok & ~ibi_storm_i & covered;

    always_comb begin
        n        = q;
        n.gate   = gate_allow_i;
        n.redisc = 1'b0;
        unique case (q.st)
            ST_NORMAL: begin
                n.tmr  = '0;
                n.rtry = '0;
                if (gate_allow_i && !q.gate) begin
                    n.st      = ST_PRECHECK;
                    n.rsn     = RSN_NONE;
                    n.rsn_cnt = '0;
                    n.rsn_seg = seg_id_i;
                end
            end
            ST_PRECHECK: begin
                n.miss = missing;
                if (purity_i != PUR_NATIVE_ONLY) begin
                    n.st      = ST_FALLBACK;
                    n.rsn     = RSN_BUS_PURITY;
                    n.rsn_cnt = REC_W'(q.rtry);
                    n.rsn_seg = seg_id_i;
                end else if (pre_pass) begin
                    n.st = ST_HDR;
                end else if (q.tmr == TMR_LAST) begin
                    if (q.rtry != RTRY_MAX) begin
                        n.rtry = q.rtry + 1'b1;
                        n.tmr  = '0;
                    end else begin
                        n.st      = ST_FALLBACK;
                        n.rsn_cnt = REC_W'(q.rtry);
                        n.rsn_seg = seg_id_i;
                        if (!covered) begin
                            n.rsn = RSN_TGT_NOT_READY;
                        end else if (ibi_storm_i) begin
                            n.rsn = RSN_BUS_IBI_STORM;
                        end else begin
                            n.rsn = RSN_BUS_NOT_IDLE;
                        end
                    end
                end else begin
                    n.tmr = q.tmr + 1'b1;
                end
            end
            ST_HDR: begin
                n.tts = '0;
                if (to_long_i) begin
                    n.st      = ST_VERIFY;
                    n.rsn     = RSN_LNK_LONG_TO;
                    n.rsn_cnt = '0;
                    n.rsn_seg = seg_id_i;
                end else if (link_inc && link_at_lim) begin
                    n.st      = ST_VERIFY;
                    n.rsn     = RSN_LNK_ERRORS;
                    n.rsn_cnt = REC_W'(LINK_RETRY_LIM);
                    n.rsn_seg = seg_id_i;
                end else if (short_inc && short_at_lim) begin
                    n.st      = ST_VERIFY;
                    n.rsn     = RSN_LNK_SHORT_TO;
                    n.rsn_cnt = REC_W'(SHORT_RETRY_LIM);
                    n.rsn_seg = seg_id_i;
                end else if (exit_req_i) begin
                    n.st = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (verify_done_i) begin
                    if (verify_pass_i && bus_idle_i) begin
                        n.st      = ST_NORMAL;
                        n.tts_out = q.tts + 1'b1;
                    end else begin
                        n.st      = ST_FALLBACK;
                        n.redisc  = 1'b1;
                        n.rsn_seg = seg_id_i;
                        n.rsn     = verify_pass_i ? RSN_BUS_NOT_IDLE : RSN_TGT_VERIFY;
                    end
                end else if (q.tts == VFY_LAST) begin
                    n.st      = ST_FALLBACK;
                    n.redisc  = 1'b1;
                    n.rsn_seg = seg_id_i;
                    n.rsn     = RSN_TGT_VERIFY_TO;
                end else begin
                    n.tts = q.tts + 1'b1;
                end
            end
            ST_FALLBACK: begin
                if (bus_idle_i) begin
                    n.st = ST_NORMAL;
                end
            end
            default: n.st = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_NORMAL, default: '0};
        end else begin
            q <= n;
        end
    end

    assign mode_o           = q.st;
    assign hdr_en_o         = in_hdr;
    assign reason_o         = q.rsn;
    assign reason_seg_o     = q.rsn_seg;
    assign reason_cnt_o     = q.rsn_cnt;
    assign missing_o        = q.miss;
    assign rediscover_o     = q.redisc;
    assign time_to_stable_o = q.tts_out;

    // R4: HDR is only entered from a precheck whose proofs all held
    a_r4_entry_proven: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hdr_en_o) |-> $past(q.st == ST_PRECHECK && purity_i == PUR_NATIVE_ONLY
                                  && idle_ok && !ibi_storm_i && covered));

    // R2: precheck is only reached from Normal
    a_r2_precheck_from_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_PRECHECK && $past(q.st) != ST_PRECHECK) |-> $past(q.st == ST_NORMAL && gate_allow_i));

    // R10: verify hands back to Normal only on a passing, idle result
    a_r10_verify_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_NORMAL && $past(q.st) == ST_VERIFY) |-> $past(verify_done_i && verify_pass_i && bus_idle_i));

    // R11: rediscovery request is a single pulse during Fallback
    a_r11_redisc_in_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rediscover_o |-> (mode_o == 3'd4));
    a_r11_redisc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rediscover_o |=> !rediscover_o);

    // R12: Fallback leaves only towards Normal
    a_r12_fallback_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_FALLBACK) |=> (q.st == ST_FALLBACK || q.st == ST_NORMAL));

endmodule

// File: tb/test_hdr_guard_ctrl.sv
`timescale 1ns/1ps
module test_hdr_guard_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] seg_id = 3'd0;
    logic       gate = 1'b0;
    logic [1:0] purity = 2'd2;
    logic       idle = 1'b1;
    logic       storm = 1'b0;
    logic [3:0] ready = 4'hF;
    logic [3:0] crit = 4'hF;
    logic       e_crc = 1'b0, e_rty = 1'b0, t_sh = 1'b0, t_lg = 1'b0, x_req = 1'b0;
    logic       v_done = 1'b0, v_pass = 1'b0;
    logic [2:0] mode;
    logic       hdr_en;
    logic [3:0] reason;
    logic [2:0] rseg;
    logic [7:0] rcnt;
    logic [3:0] miss;
    logic       redisc;
    logic [15:0] tts;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    hdr_guard_ctrl #(
        .N_TGT(4), .SEG_W(3), .GUARD_CYC(3), .ENTRY_BUDGET(4), .ENTRY_RETRIES(1),
        .LINK_RETRY_LIM(2), .SHORT_RETRY_LIM(1), .VERIFY_BUDGET(8), .TTS_W(16), .REC_W(8)
    ) i_hdr_guard_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .seg_id_i(seg_id), .gate_allow_i(gate),
        .purity_i(purity), .bus_idle_i(idle), .ibi_storm_i(storm),
        .ready_mask_i(ready), .crit_mask_i(crit), .err_crc_i(e_crc), .err_retry_i(e_rty),
        .to_short_i(t_sh), .to_long_i(t_lg), .exit_req_i(x_req),
        .verify_done_i(v_done), .verify_pass_i(v_pass),
        .mode_o(mode), .hdr_en_o(hdr_en), .reason_o(reason), .reason_seg_o(rseg),
        .reason_cnt_o(rcnt), .missing_o(miss), .rediscover_o(redisc), .time_to_stable_o(tts)
    );

    typedef struct packed {
        logic [1:0] pur;
        logic       stm;
        logic [3:0] rdy;
        logic [3:0] crt;
        logic [2:0] exp_mode;
        logic [3:0] exp_miss;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{2'd2, 1'b0, 4'hF, 4'hF, 3'd2, 4'h0},
        '{2'd2, 1'b0, 4'h5, 4'h7, 3'd1, 4'h2},
        '{2'd1, 1'b0, 4'hF, 4'hF, 3'd4, 4'h0},
        '{2'd0, 1'b0, 4'h0, 4'h3, 3'd4, 4'h3},
        '{2'd2, 1'b1, 4'hF, 4'hF, 3'd1, 4'h0},
        '{2'd2, 1'b0, 4'h0, 4'h0, 3'd2, 4'h0},
        '{2'd3, 1'b0, 4'hF, 4'hF, 3'd4, 4'h0},
        '{2'd2, 1'b0, 4'h8, 4'h9, 3'd1, 4'h1}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_normal();
        gate = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (mode == 3'd0) break;
            if (mode == 3'd2) begin
                x_req = 1'b1; tick(); x_req = 1'b0;
            end else if (mode == 3'd3) begin
                idle = 1'b1; v_done = 1'b1; v_pass = 1'b1; tick(); v_done = 1'b0; v_pass = 1'b0;
            end else begin
                idle = 1'b1; tick();
            end
        end
        purity = 2'd2; storm = 1'b0; ready = 4'hF; crit = 4'hF; idle = 1'b1;
        tick();
    endtask

    task automatic enter_hdr();
        purity = 2'd2; storm = 1'b0; ready = 4'hF; crit = 4'hF; idle = 1'b1; gate = 1'b0;
        repeat (4) tick();
        gate = 1'b1; tick(); tick();
        check("R4 entry reaches HDR", int'(mode), 2);
        check("R4 hdr_en in HDR", int'(hdr_en), 1);
        gate = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 mode", int'(mode), 0);
        check("R1 hdr_en", int'(hdr_en), 0);
        check("R1 reason", int'(reason), 0);
        check("R1 missing", int'(miss), 0);
        check("R1 rediscover", int'(redisc), 0);
        check("R1 tts", int'(tts), 0);

        // vector table: R4 R5 R6 across precheck input patterns
        for (int i = 0; i < 8; i++) begin
            purity = VEC[i].pur; storm = VEC[i].stm; ready = VEC[i].rdy; crit = VEC[i].crt;
            idle = 1'b1; gate = 1'b0;
            repeat (4) tick();
            gate = 1'b1; tick();
            check("R2 precheck after gate rise", int'(mode), 1);
            tick();
            check("R4/R5 mode after precheck edge", int'(mode), int'(VEC[i].exp_mode));
            check("R6 missing vector", int'(miss), int'(VEC[i].exp_miss));
            if (VEC[i].exp_mode == 3'd4)
                check("R5 purity reason", int'(reason), 4);
            go_normal();
        end

        // R2: gate level held high across return to Normal starts nothing
        enter_hdr();
        gate = 1'b1;
        x_req = 1'b1; tick(); x_req = 1'b0;
        v_done = 1'b1; v_pass = 1'b1; tick(); v_done = 1'b0; v_pass = 1'b0;
        check("R10 back to Normal", int'(mode), 0);
        tick(); tick();
        check("R2 held gate ignored", int'(mode), 0);
        go_normal();

        // R3: guard time
        idle = 1'b0; tick();
        idle = 1'b1; gate = 1'b1; tick();
        tick(); tick();
        check("R3 guard not yet met", int'(mode), 1);
        tick();
        check("R3 guard met enters HDR", int'(mode), 2);
        go_normal();

        // R7: budget exhaustion on missing target
        seg_id = 3'd5; ready = 4'h0; crit = 4'h1; gate = 1'b0; tick();
        gate = 1'b1; tick();
        repeat (7) tick();
        check("R7 last window still precheck", int'(mode), 1);
        tick();
        check("R7 fallback after budget", int'(mode), 4);
        check("R7 reason not ready", int'(reason), 8);
        check("R13 target class", int'(reason[3:2]), 2);
        check("R7 retry count", int'(rcnt), 1);
        check("R7 segment id", int'(rseg), 5);
        check("R6 missing held", int'(miss), 1);
        go_normal();

        // R7: success in retry window
        ready = 4'h0; crit = 4'h1; gate = 1'b0; tick();
        gate = 1'b1; tick();
        repeat (5) tick();
        ready = 4'h1; tick();
        check("R7 late ready enters HDR", int'(mode), 2);
        check("R7 reason stays clear", int'(reason), 0);
        go_normal();

        // R7 storm expiry, then R12 fallback behaviour
        storm = 1'b1; gate = 1'b0; tick();
        gate = 1'b1; tick();
        repeat (8) tick();
        check("R7 storm fallback", int'(mode), 4);
        check("R7 storm reason", int'(reason), 6);
        check("R13 bus class", int'(reason[3:2]), 1);
        storm = 1'b0; idle = 1'b0; gate = 1'b0; tick();
        gate = 1'b1; tick();
        check("R12 gate ignored in fallback", int'(mode), 4);
        idle = 1'b1; tick();
        check("R12 idle returns to Normal", int'(mode), 0);
        tick();
        check("R12 no stale gate restart", int'(mode), 0);
        gate = 1'b0; tick(); gate = 1'b1; tick();
        check("R12 fresh gate restarts", int'(mode), 1);
        go_normal();

        // R8 link errors, R10 time to stable
        enter_hdr();
        e_crc = 1'b1; tick(); e_crc = 1'b0;
        e_rty = 1'b1; tick(); e_rty = 1'b0;
        check("R8 within limit stays HDR", int'(mode), 2);
        e_crc = 1'b1; tick(); e_crc = 1'b0;
        check("R8 exit to verify", int'(mode), 3);
        check("R8 hdr_en low", int'(hdr_en), 0);
        check("R8 reason", int'(reason), 12);
        check("R13 link class", int'(reason[3:2]), 3);
        check("R8 count", int'(rcnt), 2);
        tick(); tick();
        v_done = 1'b1; v_pass = 1'b1; tick(); v_done = 1'b0; v_pass = 1'b0;
        check("R10 Normal after verify", int'(mode), 0);
        check("R10 time to stable", int'(tts), 3);
        go_normal();

        // R9 short timeouts, R11 verify pass but bus busy
        enter_hdr();
        t_sh = 1'b1; tick();
        check("R9 first short stays HDR", int'(mode), 2);
        tick(); t_sh = 1'b0;
        check("R9 short limit exit", int'(mode), 3);
        check("R9 short reason", int'(reason), 13);
        idle = 1'b0; v_done = 1'b1; v_pass = 1'b1; tick(); v_done = 1'b0; v_pass = 1'b0;
        check("R11 busy verify fallback", int'(mode), 4);
        check("R11 busy reason", int'(reason), 5);
        check("R11 rediscover pulse", int'(redisc), 1);
        tick();
        check("R11 rediscover one cycle", int'(redisc), 0);
        go_normal();

        // R9 long timeout precedence, R11 verify fail
        enter_hdr();
        t_lg = 1'b1; e_crc = 1'b1; x_req = 1'b1; tick();
        t_lg = 1'b0; e_crc = 1'b0; x_req = 1'b0;
        check("R9 long exit", int'(mode), 3);
        check("R9 long reason wins", int'(reason), 14);
        v_done = 1'b1; v_pass = 1'b0; tick(); v_done = 1'b0;
        check("R11 failed verify", int'(mode), 4);
        check("R11 fail reason", int'(reason), 9);
        check("R11 rediscover", int'(redisc), 1);
        go_normal();

        // R11 verify timeout
        enter_hdr();
        x_req = 1'b1; tick(); x_req = 1'b0;
        check("R11 clean exit reason clear", int'(reason), 0);
        repeat (7) tick();
        check("R11 verify still pending", int'(mode), 3);
        tick();
        check("R11 verify timeout fallback", int'(mode), 4);
        check("R11 timeout reason", int'(reason), 10);
        check("R11 timeout rediscover", int'(redisc), 1);
        go_normal();

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule